// File: doc/BRIEF.md
# I2C Controller Message Sequencer

This block is the byte-level engine of an I2C controller. It runs a transaction as a series of messages. Each message is a read or a write with a 7-bit target address, a length of at least one byte, and a flag that says whether a STOP ends it. From idle it opens the bus with START and sends the address byte. Write data comes from a transmit FIFO, and read data goes into a receive FIFO.

A message without the STOP flag leaves the bus held, so the next message continues the transaction. A write that follows a held write sends only data bytes. A read that follows a held read receives data at once. A change of direction issues a repeated START and a fresh address byte.

Reads of any length pass through the receive FIFO. The engine holds the clock, modelled as no read request, whenever the FIFO is full. It NACKs the final byte of a read that ends with STOP. Target NACKs and bus errors end the transaction with a STOP and a status code.

The bus side is a byte-operation handshake. The engine holds `bus_req` with an operation (START, WRITE, READ or STOP) until the target model returns a one-cycle `bus_ack`. The three data paths are valid/ready streams:
- A message is taken on a cycle with `msg_valid && msg_ready`.
- A transmit byte is taken on a cycle with `tx_valid && tx_ready`, and `tx_ready` is low while the transmit FIFO is full.
- A receive byte leaves on a cycle with `rx_valid && rx_ready`. `rx_data` holds steady while `rx_ready` is low.

Top module: `i2c_msg_engine`

## Requirements
- R1: After reset the engine is idle: `msg_ready`=1, `bus_req`=0, `done`=0, `rx_valid`=0 and `tx_ready`=1.
- R2: A message accepted while idle issues START (bus_op 0), then a WRITE (bus_op 1) of the address byte `{addr[6:0], rd}`, where bit 0 is 1 for a read and 0 for a write.
- R3: A write sends `msg_len` bytes from the transmit FIFO in push order. Each byte is held on `bus_wdata` until it is acknowledged. While the FIFO is empty no write request is made.
- R4: A write without STOP reports `done` with status 0 after its last byte is acknowledged and issues no STOP. A following write sends only its data bytes, with no START and no address.
- R5: A read after a held write, or a write after a held read, issues START and then the address byte with the new direction bit. A read after a held read issues READ operations (bus_op 2) at once.
- R6: A read stores `msg_len` bytes into the receive FIFO in order. It never requests a read while the FIFO holds FIFO_DEPTH bytes, and it resumes when space frees, so a read longer than the FIFO completes.
- R7: `bus_nack` is 1 on the final READ of a message with STOP. It is 0 on every other READ, including the final READ of a message without STOP.
- R8: After the last byte of a message with STOP, a STOP (bus_op 3) is issued without waiting for the receive FIFO to drain. `done` pulses with status 0 after the STOP is acknowledged, and the engine returns to idle.
- R9: A target NACK on an address or write byte gives `done` with status 1, then a STOP, and returns the engine to idle. The untransmitted transmit FIFO content is discarded.
- R10: A bus error on any operation gives `done` with status 2, then a STOP, and returns the engine to idle with the transmit FIFO emptied.
- R11: `msg_ready` is 1 only while idle or holding the bus, and falls after a message is accepted. `tx_ready` is 0 when the transmit FIFO holds FIFO_DEPTH bytes. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message descriptor valid |
| msg_ready | output | 1 | Engine can take a message |
| msg_read | input | 1 | 1 = read message, 0 = write |
| msg_stop | input | 1 | End the message with STOP |
| msg_addr | input | 7 | Target address |
| msg_len | input | LEN_W | Byte count, at least 1 |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit FIFO has space |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Consumer takes a byte |
| rx_data | output | 8 | Oldest received byte |
| done | output | 1 | One-cycle message completion pulse |
| done_status | output | 2 | 0 ok, 1 target NACK, 2 bus error |
| bus_req | output | 1 | Byte operation requested |
| bus_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| bus_wdata | output | 8 | Byte for a WRITE operation |
| bus_nack | output | 1 | NACK the byte of this READ |
| bus_ack | input | 1 | Operation finished (one cycle) |
| bus_rdata | input | 8 | Byte returned by a READ |
| bus_nak | input | 1 | Target did not acknowledge the WRITE |
| bus_err | input | 1 | Bus error on this operation |

## Verification
The receive FIFO can take a byte from the bus and give one to the consumer in the same cycle. Reads of 33 and 40 bytes are run with `rx_ready` toggling every cycle, so that pushes and pops coincide near the full mark. Each is judged by the count and the arithmetic sequence of the delivered bytes.

The transmit FIFO can likewise be refilled on the cycle the engine pops it. This happens when bytes are pushed during a stalled write. The bytes on the bus must then match push order exactly.

// File: rtl/i2c_msg_pkg.sv
package i2c_msg_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_START, S_WAIT_RESTART, S_WRITE, S_WRITE_HOLD,
    S_READ, S_READ_HOLD, S_WAIT_STOP, S_RECOVER
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_NACK = 2'd1, ST_BUSERR = 2'd2
  } done_st_e;
endpackage

// File: rtl/i2c_msg_fifo.sv
module i2c_msg_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (!full || pop));
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_msg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic             msg_read,
  input  logic             msg_stop,
  input  logic [6:0]       msg_addr,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             tx_empty,
  input  logic [7:0]       tx_head,
  output logic             tx_pop,
  output logic             tx_flush,
  input  logic             rx_full,
  output logic             rx_push,
  output logic             done,
  output logic [1:0]       done_status,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [7:0]       bus_wdata,
  output logic             bus_nack,
  input  logic             bus_ack,
  input  logic             bus_nak,
  input  logic             bus_err
);
  seq_state_e       state;
  logic             addr_ph, rd_q, stop_q, ok_on_stop;
  logic [6:0]       addr_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic             ack, last, msg_fire;

  assign msg_ready = (state == S_IDLE) || (state == S_WRITE_HOLD) || (state == S_READ_HOLD);
  assign msg_fire  = msg_valid && msg_ready;
  assign ack       = bus_ack && bus_req;
  assign last      = (cnt == len_q - 1'b1);

  always_comb begin
    bus_req   = 1'b0;
    bus_op    = OP_START;
    bus_wdata = '0;
    bus_nack  = 1'b0;
    unique case (state)
      S_WAIT_START, S_WAIT_RESTART: begin
        bus_req   = 1'b1;
        bus_op    = addr_ph ? OP_WRITE : OP_START;
        bus_wdata = {addr_q, rd_q};
      end
      S_WRITE: begin
        bus_req   = !tx_empty;
        bus_op    = OP_WRITE;
        bus_wdata = tx_head;
      end
      S_READ: begin
        bus_req  = !rx_full;
        bus_op   = OP_READ;
        bus_nack = stop_q && last;
      end
      S_WAIT_STOP, S_RECOVER: begin
        bus_req = 1'b1;
        bus_op  = OP_STOP;
      end
      default: ;
    endcase
  end

  assign tx_pop   = ack && (state == S_WRITE);
  assign rx_push  = ack && (state == S_READ) && !bus_err;
  assign tx_flush = ack && (bus_err || (bus_nak && bus_op == OP_WRITE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      addr_ph     <= 1'b0;
      rd_q        <= 1'b0;
      stop_q      <= 1'b0;
      ok_on_stop  <= 1'b0;
      addr_q      <= '0;
      len_q       <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      done_status <= ST_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE, S_WRITE_HOLD, S_READ_HOLD: if (msg_fire) begin
          rd_q    <= msg_read;
          stop_q  <= msg_stop;
          addr_q  <= msg_addr;
          len_q   <= msg_len;
          cnt     <= '0;
          addr_ph <= 1'b0;
          if (state == S_IDLE)                        state <= S_WAIT_START;
          else if (state == S_WRITE_HOLD && !msg_read) state <= S_WRITE;
          else if (state == S_READ_HOLD && msg_read)    state <= S_READ;
          else                                          state <= S_WAIT_RESTART;
        end
        S_WAIT_START, S_WAIT_RESTART: if (ack) begin
          if (bus_err) begin
            state <= S_RECOVER; done <= 1'b1; done_status <= ST_BUSERR;
          end else if (!addr_ph) begin
            addr_ph <= 1'b1;
          end else if (bus_nak) begin
            state <= S_WAIT_STOP; ok_on_stop <= 1'b0;
            done <= 1'b1; done_status <= ST_NACK;
          end else begin
            state <= rd_q ? S_READ : S_WRITE;
          end
        end
        S_WRITE, S_READ: if (ack) begin
          if (bus_err) begin
            state <= S_RECOVER; done <= 1'b1; done_status <= ST_BUSERR;
          end else if (bus_nak && state == S_WRITE) begin
            state <= S_WAIT_STOP; ok_on_stop <= 1'b0;
            done <= 1'b1; done_status <= ST_NACK;
          end else begin
            cnt <= cnt + 1'b1;
            if (last) begin
              if (stop_q) begin
                state <= S_WAIT_STOP; ok_on_stop <= 1'b1;
              end else begin
                state <= (state == S_WRITE) ? S_WRITE_HOLD : S_READ_HOLD;
                done <= 1'b1; done_status <= ST_OK;
              end
            end
          end
        end
        S_WAIT_STOP: if (ack) begin
          state <= S_IDLE;
          if (ok_on_stop) begin
            done <= 1'b1; done_status <= ST_OK;
          end
        end
        S_RECOVER: if (ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  msg_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_ready);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata)));
  // R8
  idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_IDLE) |-> $past(bus_ack && bus_op == OP_STOP));
  // R10
  err_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == ST_BUSERR) |-> $past(bus_err && bus_ack));
  // R7
  last_nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_req && bus_op == OP_READ && bus_nack && !bus_err) |=> (bus_op == OP_STOP && bus_req));
endmodule

// File: rtl/i2c_msg_engine.sv
module i2c_msg_engine #(
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic             msg_read,
  input  logic             msg_stop,
  input  logic [6:0]       msg_addr,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic [1:0]       done_status,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [7:0]       bus_wdata,
  output logic             bus_nack,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_nak,
  input  logic             bus_err
);
  logic tx_full, tx_empty, tx_pop, tx_flush;
  logic rx_full, rx_empty, rx_push;
  logic [7:0] tx_head;

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;

  i2c_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_valid && tx_ready), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  i2c_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .push(rx_push), .wdata(bus_rdata),
    .pop(rx_valid && rx_ready), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  i2c_msg_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_read(msg_read),
    .msg_stop(msg_stop), .msg_addr(msg_addr), .msg_len(msg_len),
    .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop), .tx_flush(tx_flush),
    .rx_full(rx_full), .rx_push(rx_push),
    .done(done), .done_status(done_status),
    .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_nack(bus_nack),
    .bus_ack(bus_ack), .bus_nak(bus_nak), .bus_err(bus_err)
  );
endmodule

// File: tb/i2c_msg_engine_tb.sv
module i2c_msg_engine_tb_top;
  localparam int DEPTH = 32;
  localparam int OPS = 0, OPW = 1, OPR = 2, OPP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 0, msg_read = 0, msg_stop = 0, msg_ready;
  logic [6:0] msg_addr = '0;
  logic [7:0] msg_len = '0;
  logic tx_valid = 0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid, rx_ready = 0;
  logic [7:0] rx_data;
  logic done;
  logic [1:0] done_status;
  logic bus_req, bus_nack;
  logic [1:0] bus_op;
  logic [7:0] bus_wdata;
  logic bus_ack = 0, bus_nak = 0, bus_err = 0;
  logic [7:0] bus_rdata = '0;

  always #2 clk = ~clk;

  i2c_msg_engine #(.FIFO_DEPTH(DEPTH), .LEN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_read(msg_read), .msg_stop(msg_stop), .msg_addr(msg_addr), .msg_len(msg_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .done(done), .done_status(done_status),
    .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_nack(bus_nack),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_nak(bus_nak), .bus_err(bus_err)
  );

  int nchk = 0, nfail = 0;
  int top [1024];
  int tdat [1024];
  int tnk [1024];
  int tn = 0, rdc = 0;
  int ack_dly = 0, nak_at = -1, err_at = -1;
  int rx_log [512];
  int rx_n = 0;
  int rx_mode = 0;

  function automatic logic [7:0] rbyte(input int k);
    return 8'(8'h3C + k * 7);
  endfunction

  // behavioural target: answers each requested operation after ack_dly cycles
  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 0; bus_nak = 0; bus_err = 0; wc = 0;
      end else if (bus_req) begin
        if (wc >= ack_dly) begin
          top[tn] = int'(bus_op); tdat[tn] = int'(bus_wdata); tnk[tn] = int'(bus_nack);
          bus_nak = (tn == nak_at) && (bus_op == 2'd1);
          bus_err = (tn == err_at);
          if (bus_op == 2'd2) begin bus_rdata = rbyte(rdc); rdc++; end
          tn++;
          bus_ack = 1;
        end else wc++;
      end else wc = 0;
    end
  end

  // receive consumer: records each handshake the preceding edge performed
  initial begin
    logic v_prev, tog;
    logic [7:0] d_prev;
    v_prev = 0; d_prev = '0; tog = 0;
    forever begin
      @(negedge clk);
      if (rx_ready && v_prev) begin rx_log[rx_n] = int'(d_prev); rx_n++; end
      v_prev = rx_valid; d_prev = rx_data; tog = ~tog;
      rx_ready = (rx_mode == 1) || (rx_mode == 2 && tog);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic chk_op(input string req, input int idx, input int op, input int dat);
    chk_eq(req, top[idx], op);
    if (op == OPW) chk_eq(req, tdat[idx], dat);
  endtask

  task automatic push_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      tx_valid = 1; tx_data = 8'(base + i * 5);
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 0;
    end
  endtask

  task automatic send_msg(input bit rd, input bit stp, input int addr, input int len);
    msg_valid = 1; msg_read = rd; msg_stop = stp;
    msg_addr = 7'(addr); msg_len = 8'(len);
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic wait_done(output int st);
    bit got;
    got = 0; st = -1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin st = int'(done_status); got = 1; break; end
    end
    chk(got, "R11 done missing", 0, 1);
    @(negedge clk);
    chk_eq("R11 done one cycle", int'(done), 0);
  endtask

  int lens [7] = '{1, 2, 3, 31, 32, 33, 40};

  initial begin
    int t0, r0, x0, st, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 msg_ready", int'(msg_ready), 1);
    chk_eq("R1 bus_req", int'(bus_req), 0);
    chk_eq("R1 done", int'(done), 0);
    chk_eq("R1 rx_valid", int'(rx_valid), 0);
    chk_eq("R1 tx_ready", int'(tx_ready), 1);
    rst_n = 1;
    @(negedge clk);
    rx_mode = 1;

    // write sweep with STOP
    for (int len = 1; len <= 6; len++) begin
      ack_dly = len % 3;
      push_bytes(len, 16 * len);
      t0 = tn;
      send_msg(0, 1, 7'h20 + len, len);
      chk_eq("R11 ready falls", int'(msg_ready), 0);
      wait_done(st);
      chk_eq("R8 status ok", st, 0);
      chk_op("R2 start", t0, OPS, 0);
      chk_op("R2 addr write", t0 + 1, OPW, (32 + len) * 2);
      for (int i = 0; i < len; i++) chk_op("R3 data", t0 + 2 + i, OPW, (16 * len + i * 5) & 255);
      chk_op("R8 stop", t0 + 2 + len, OPP, 0);
      chk_eq("R8 idle", int'(msg_ready), 1);
    end

    // read sweep with STOP, including lengths above the FIFO depth
    for (int j = 0; j < 7; j++) begin
      ack_dly = j % 3;
      rx_mode = (lens[j] > DEPTH) ? 2 : 1;
      t0 = tn; r0 = rdc; x0 = rx_n;
      send_msg(1, 1, 7'h51, lens[j]);
      wait_done(st);
      chk_eq("R8 status ok", st, 0);
      chk_op("R2 addr read", t0 + 1, OPW, 8'hA3);
      for (int i = 0; i < lens[j]; i++) begin
        chk_eq("R6 read op", top[t0 + 2 + i], OPR);
        chk_eq("R7 nack bit", tnk[t0 + 2 + i], (i == lens[j] - 1) ? 1 : 0);
      end
      chk_op("R8 stop after read", t0 + 2 + lens[j], OPP, 0);
      repeat (100) @(negedge clk);
      chk_eq("R6 byte count", rx_n - x0, lens[j]);
      for (int i = 0; i < lens[j]; i++) chk_eq("R6 byte value", rx_log[x0 + i], int'(rbyte(r0 + i)));
    end
    rx_mode = 1; ack_dly = 1;

    // held writes, then a read with repeated START
    push_bytes(5, 100);
    t0 = tn;
    send_msg(0, 0, 7'h11, 2);
    wait_done(st);
    chk_eq("R4 status ok", st, 0);
    repeat (20) @(negedge clk);
    chk_eq("R4 no stop", tn - t0, 4);
    chk_eq("R4 bus held", int'(bus_req), 0);
    t0 = tn;
    send_msg(0, 0, 7'h11, 3);
    wait_done(st);
    for (int i = 0; i < 3; i++) chk_op("R4 data only", t0 + i, OPW, 100 + (2 + i) * 5);
    repeat (10) @(negedge clk);
    chk_eq("R4 no extra ops", tn - t0, 3);
    t0 = tn; r0 = rdc;
    send_msg(1, 0, 7'h11, 2);
    wait_done(st);
    chk_op("R5 restart", t0, OPS, 0);
    chk_op("R5 addr read", t0 + 1, OPW, 8'h23);
    chk_eq("R7 no nack held", tnk[t0 + 3], 0);
    t0 = tn;
    send_msg(1, 1, 7'h11, 3);
    wait_done(st);
    chk_eq("R5 read continues", top[t0], OPR);
    chk_eq("R7 final nack", tnk[t0 + 2], 1);
    chk_op("R8 stop", t0 + 3, OPP, 0);
    // write after held read
    send_msg(1, 0, 7'h12, 1);
    wait_done(st);
    push_bytes(1, 77);
    t0 = tn;
    send_msg(0, 1, 7'h12, 1);
    wait_done(st);
    chk_op("R5 restart write", t0, OPS, 0);
    chk_op("R5 addr write", t0 + 1, OPW, 8'h24);
    chk_op("R5 data", t0 + 2, OPW, 77);
    repeat (10) @(negedge clk);

    // receive FIFO full stall
    rx_mode = 0; ack_dly = 0;
    t0 = tn; r0 = rdc; x0 = rx_n;
    send_msg(1, 0, 7'h33, 40);
    repeat (300) @(negedge clk);
    n = 0;
    for (int i = t0; i < tn; i++) if (top[i] == OPR) n++;
    chk_eq("R6 stall at depth", n, DEPTH);
    chk_eq("R6 no request when full", int'(bus_req), 0);
    rx_mode = 1;
    wait_done(st);
    chk_eq("R6 status", st, 0);
    repeat (60) @(negedge clk);
    chk_eq("R6 all bytes", rx_n - x0, 40);
    for (int i = 0; i < 40; i++) chk_eq("R6 value", rx_log[x0 + i], int'(rbyte(r0 + i)));
    t0 = tn;
    send_msg(1, 1, 7'h33, 2);
    wait_done(st);
    chk_eq("R5 held read no start", top[t0], OPR);

    // STOP before the receive FIFO drains
    rx_mode = 0; x0 = rx_n;
    send_msg(1, 1, 7'h34, 5);
    wait_done(st);
    chk_eq("R8 done before drain", int'(rx_valid), 1);
    rx_mode = 1;
    repeat (20) @(negedge clk);
    chk_eq("R8 bytes later", rx_n - x0, 5);

    // transmit FIFO empty stall
    push_bytes(2, 40);
    t0 = tn;
    send_msg(0, 1, 7'h35, 4);
    repeat (100) @(negedge clk);
    chk_eq("R3 stall on empty", tn - t0, 4);
    chk_eq("R3 no request", int'(bus_req), 0);
    push_bytes(2, 50);
    wait_done(st);
    chk_op("R3 third", t0 + 4, OPW, 50);
    chk_op("R3 fourth", t0 + 5, OPW, 55);

    // transmit FIFO full
    push_bytes(DEPTH, 3);
    chk_eq("R11 tx full", int'(tx_ready), 0);
    t0 = tn;
    send_msg(0, 1, 7'h36, DEPTH);
    wait_done(st);
    chk_op("R3 last of depth", t0 + 1 + DEPTH, OPW, (3 + (DEPTH - 1) * 5) & 255);

    // NACK on address
    push_bytes(3, 9);
    t0 = tn; nak_at = tn + 1;
    send_msg(0, 1, 7'h40, 3);
    wait_done(st);
    nak_at = -1;
    chk_eq("R9 status nack", st, 1);
    repeat (12) @(negedge clk);
    chk_op("R9 stop", t0 + 2, OPP, 0);
    chk_eq("R9 op count", tn - t0, 3);
    push_bytes(1, 200);
    t0 = tn;
    send_msg(0, 1, 7'h40, 1);
    wait_done(st);
    chk_op("R9 idle start", t0, OPS, 0);
    chk_op("R9 stale dropped", t0 + 2, OPW, 200);

    // NACK on second data byte
    push_bytes(4, 60);
    t0 = tn; nak_at = tn + 3;
    send_msg(0, 1, 7'h41, 4);
    wait_done(st);
    nak_at = -1;
    chk_eq("R9 data nack", st, 1);
    repeat (12) @(negedge clk);
    chk_op("R9 stop after data", t0 + 4, OPP, 0);
    push_bytes(1, 201);
    t0 = tn;
    send_msg(0, 1, 7'h41, 1);
    wait_done(st);
    chk_op("R9 leftovers dropped", t0 + 2, OPW, 201);

    // bus error during read
    t0 = tn; err_at = tn + 3;
    send_msg(1, 1, 7'h42, 6);
    wait_done(st);
    err_at = -1;
    chk_eq("R10 status err", st, 2);
    repeat (12) @(negedge clk);
    chk_op("R10 stop", t0 + 4, OPP, 0);
    chk_eq("R10 op count", tn - t0, 5);
    repeat (10) @(negedge clk);

    // bus error during write with leftovers
    push_bytes(5, 90);
    t0 = tn; err_at = tn + 2;
    send_msg(0, 1, 7'h43, 5);
    wait_done(st);
    err_at = -1;
    chk_eq("R10 write err", st, 2);
    repeat (12) @(negedge clk);
    push_bytes(1, 202);
    t0 = tn;
    send_msg(0, 1, 7'h43, 1);
    wait_done(st);
    chk_op("R10 idle start", t0, OPS, 0);
    chk_op("R10 fifo emptied", t0 + 2, OPW, 202);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule